// File: doc/BRIEF.md
# Synchronous serial ADC frame controller

This block runs one synchronous serial exchange with an external analog-to-digital converter each time the CPU asks for one. A single control write carries every setting at once. That write holds the total length of the frame in shift clocks, the enable for a free-running sample clock, the start request and the configuration word to be sent. While the frame runs, the block drives its own shift clock and moves the configuration bits out most significant bit first. It then lets a fixed number of null periods go by without capturing them. After that it shifts every remaining input bit into a right-justified result register. A busy output is high while a frame is in flight.

A mode input selects the configuration source. When the input is low, the lower byte of the control word is sent as a fixed 8-bit configuration. When it is high, a wider configuration field in the upper half-word is sent instead, and a 7-bit length field sets how many of its bits go out. The null count for each mode and the clock divider are parameters. A control write without the start request changes only the stored settings. Today that setting is the sample-clock enable. The sample clock runs at twice the shift-clock rate and is independent of frames.

Top module: `sadc_frame_ctrl`

## Requirements
- R1: After reset, busy is 0, adc_sclk is 1, adc_dout is 0, result is 0 and smp_clk is 0.
- R2: An accepted frame produces exactly N rising edges on adc_sclk. N is ctl_wdata[12:8] when ext_mode is 0, and ctl_wdata[12:7] when ext_mode is 1.
- R3: With ext_mode 0, the configuration byte ctl_wdata[7:0] goes out on adc_dout, one bit per shift clock, bit 7 first. adc_dout changes only at a falling edge of adc_sclk or while adc_sclk is low, and it is stable while adc_sclk is high.
- R4: With ext_mode 1, the configuration bits come from the low C bits of ctl_wdata[31:16], sent highest first. C is ctl_wdata[6:0] clamped to 16. If N < C, only the first N of these bits are sent.
- R5: After the configuration bits, adc_dout is 0 for the rest of the frame. The following null periods, LEG_NULLS (1) in mode 0 and EXT_NULLS (3) in mode 1, are not captured.
- R6: result is cleared when a frame starts. Each later period samples adc_din at the rising edge of adc_sclk and shifts it into the result LSB, so result holds the last RES_W (16) captured bits, right-justified.
- R7: busy rises in the cycle after an accepted start write and falls after the last shift period. adc_sclk is 1 whenever busy is 0.
- R8: A start write that arrives while busy is 1 has no effect on the running frame, and it does not start another frame afterwards.
- R9: A control write with bit 14 (start) at 0 starts no frame. It still loads bit 13 as the sample-clock enable.
- R10: A start write whose decoded frame length is 0 starts no frame, and busy stays 0.
- R11: While the enable is 1, smp_clk toggles every QTR_DIV system cycles. While the enable is 0, smp_clk is held at 0.
- R12: The shift clock period is 4*QTR_DIV system cycles: 2*QTR_DIV cycles low, then 2*QTR_DIV cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | One-cycle control write strobe |
| ctl_wdata | input | 32 | Control word: configuration, lengths, enable (bit 13) and start (bit 14) |
| ext_mode | input | 1 | 0 sends the fixed byte configuration; 1 sends the extension field |
| adc_din | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Shift clock; idles high |
| adc_dout | output | 1 | Serial configuration data to the converter |
| smp_clk | output | 1 | Free-running sample clock at twice the shift rate |
| busy | output | 1 | A frame is in progress |
| result | output | RES_W | Captured result, right-justified |

## Verification
The hardest state to reach from the ports is a second start write that lands in the middle of a running frame. To be useful, that write must carry a different length and configuration, so that any leak into the running frame would show up at the ports. The stimulus opens a full-length frame, waits part way into it, writes a conflicting start, and then checks that the edge count and captured value still match the first write. It also checks that the line stays idle afterwards. Seeded random frames in both modes cover configuration lengths above the clamp, frames shorter than the configuration, and results longer than the register.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions, widths and the control-word decode for
// the serial ADC frame controller. Assumes a 32-bit control word.
package sadc_pkg;

    localparam int CTRL_W     = 32;
    localparam int EXT_W      = 16;  // width of the extension config field
    localparam int EXT_LSB    = 16;  // extension field occupies [31:16]
    localparam int LEG_CFG_W  = 8;   // fixed byte configuration width
    localparam int FLEN_W     = 6;   // widest frame-length field
    localparam int CLEN_W     = 7;   // extension length field [6:0]
    localparam int BCNT_W     = 7;   // holds counts up to EXT_W + nulls
    localparam int SMP_EN_BIT = 13;
    localparam int START_BIT  = 14;

    // Settings of one frame, as latched at its start.
    typedef struct packed {
        logic [FLEN_W-1:0] frame_len;
        logic [BCNT_W-1:0] cfg_bits;
        logic [BCNT_W-1:0] cap_start;
        logic [EXT_W-1:0]  cfg_word;
    } frame_cfg_t;

    // Decode the frame length, configuration width and word for a mode.
    function automatic frame_cfg_t decode_ctrl(
        input logic [CTRL_W-1:0] w,
        input logic              ext,
        input int                leg_nulls,
        input int                ext_nulls
    );
        frame_cfg_t      f;
        logic [CLEN_W-1:0] clen;
        clen = w[CLEN_W-1:0];
        if (ext) begin
            f.frame_len = w[12:7];
            f.cfg_bits  = (clen > CLEN_W'(EXT_W)) ? BCNT_W'(EXT_W) : BCNT_W'(clen);
            f.cfg_word  = w[EXT_LSB +: EXT_W];
            f.cap_start = f.cfg_bits + BCNT_W'(ext_nulls);
        end else begin
            f.frame_len = {1'b0, w[12:8]};
            f.cfg_bits  = BCNT_W'(LEG_CFG_W);
            f.cfg_word  = {{(EXT_W-LEG_CFG_W){1'b0}}, w[LEG_CFG_W-1:0]};
            f.cap_start = f.cfg_bits + BCNT_W'(leg_nulls);
        end
        return f;
    endfunction

endpackage

// File: rtl/sadc_ctrl_reg.sv
`timescale 1ns/1ps
// Control register: holds the sample-clock enable, decodes each control
// write and raises a one-cycle launch when a start write is accepted.
// Assumes ctl_wr is a single-cycle strobe; a start is refused while busy
// or when the decoded frame length is zero.
module sadc_ctrl_reg
    import sadc_pkg::*;
#(
    parameter int LEG_NULLS = 1,
    parameter int EXT_NULLS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              ext_mode,
    input  logic              busy,
    output logic              smp_en,
    output logic              launch,
    output frame_cfg_t        launch_cfg
);

    logic smp_en_q;
    logic unused_rsvd;

    assign unused_rsvd = ctl_wdata[15];

    // Decode the incoming word for the currently selected mode.
    always_comb begin
        launch_cfg = decode_ctrl(ctl_wdata, ext_mode, LEG_NULLS, EXT_NULLS);
    end

    // Accept a start only when idle and the frame has at least one clock.
    always_comb begin
        launch = ctl_wr && ctl_wdata[START_BIT] && !busy &&
                 (launch_cfg.frame_len != '0);
    end

    // Every control write, start or not, reloads the stored enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_en_q <= 1'b0;
        end else if (ctl_wr) begin
            smp_en_q <= ctl_wdata[SMP_EN_BIT];
        end
    end

    assign smp_en = smp_en_q;

endmodule

// File: rtl/sadc_smpclk_gen.sv
`timescale 1ns/1ps
// Sample-clock generator: a free-running divider that toggles its output
// every QTR_DIV system cycles while enabled, giving twice the shift-clock
// rate. The output is registered and forced low while disabled.
module sadc_smpclk_gen #(
    parameter int QTR_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic smp_clk
);

    localparam int PRE_W = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

    logic tick;
    logic smp_q;

    generate
        if (QTR_DIV > 1) begin : g_div
            logic [PRE_W-1:0] pre_q;
            // Free-running prescaler that marks each quarter shift period.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (pre_q == PRE_W'(QTR_DIV-1)) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = (pre_q == PRE_W'(QTR_DIV-1));
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    // Toggle on each quarter tick while enabled; hold low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else if (!enable) begin
            smp_q <= 1'b0;
        end else if (tick) begin
            smp_q <= ~smp_q;
        end
    end

    assign smp_clk = smp_q;

endmodule

// File: rtl/sadc_frame_seq.sv
`timescale 1ns/1ps
// Frame sequencer: from a launch pulse it produces frame_len shift clocks
// of four quarter periods each (low half then high half). It drives config
// bits MSB first at each falling edge, samples adc_din at each rising edge
// once past the null periods, and shifts them into a right-justified result.
// Assumes adc_din is stable around the rising edge of the shift clock.
module sadc_frame_seq
    import sadc_pkg::*;
#(
    parameter int QTR_DIV = 2,
    parameter int RES_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  frame_cfg_t       launch_cfg,
    input  logic             adc_din,
    output logic             adc_sclk,
    output logic             adc_dout,
    output logic             busy,
    output logic [RES_W-1:0] result
);

    localparam int PRE_W = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

    logic              running_q;
    logic [1:0]        phase_q;
    logic [FLEN_W-1:0] bit_q;
    logic [FLEN_W-1:0] last_q;
    logic [BCNT_W-1:0] cap_q;
    logic [EXT_W-1:0]  shreg_q;
    logic              sclk_q;
    logic              dout_q;
    logic [RES_W-1:0]  res_q;
    logic [EXT_W-1:0]  aligned;
    logic              tick;
    logic              in_capture;

    // Left-align the configuration so its first bit sits at the MSB.
    always_comb begin
        aligned = launch_cfg.cfg_word << (EXT_W - int'(launch_cfg.cfg_bits));
    end

    generate
        if (QTR_DIV > 1) begin : g_div
            logic [PRE_W-1:0] pre_q;
            // Quarter-period prescaler, restarted at each launch.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (launch || pre_q == PRE_W'(QTR_DIV-1)) begin
                    pre_q <= '0;
                end else if (running_q) begin
                    pre_q <= pre_q + 1'b1;
                end
            end
            assign tick = running_q && (pre_q == PRE_W'(QTR_DIV-1));
        end else begin : g_nodiv
            assign tick = running_q;
        end
    endgenerate

    assign in_capture = ({1'b0, bit_q} >= cap_q);

    // Frame state: phase and bit counters, shift clock and data out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            phase_q   <= 2'd0;
            bit_q     <= '0;
            last_q    <= '0;
            cap_q     <= '0;
            shreg_q   <= '0;
            sclk_q    <= 1'b1;
            dout_q    <= 1'b0;
        end else if (launch) begin
            running_q <= 1'b1;
            phase_q   <= 2'd0;
            bit_q     <= '0;
            last_q    <= launch_cfg.frame_len - 1'b1;
            cap_q     <= launch_cfg.cap_start;
            shreg_q   <= aligned << 1;
            sclk_q    <= 1'b0;
            dout_q    <= aligned[EXT_W-1];
        end else if (tick) begin
            phase_q <= phase_q + 2'd1;
            if (phase_q == 2'd1) begin
                sclk_q <= 1'b1;
            end
            if (phase_q == 2'd3) begin
                if (bit_q == last_q) begin
                    running_q <= 1'b0;
                end else begin
                    bit_q   <= bit_q + 1'b1;
                    sclk_q  <= 1'b0;
                    dout_q  <= shreg_q[EXT_W-1];
                    shreg_q <= shreg_q << 1;
                end
            end
        end
    end

    // Result register: cleared on launch, shifted at capture rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (launch) begin
            res_q <= '0;
        end else if (tick && phase_q == 2'd1 && in_capture) begin
            res_q <= {res_q[RES_W-2:0], adc_din};
        end
    end

    assign adc_sclk = sclk_q;
    assign adc_dout = dout_q;
    assign busy     = running_q;
    assign result   = res_q;

endmodule

// File: rtl/sadc_frame_ctrl.sv
`timescale 1ns/1ps
// Top of the serial ADC frame controller: control register, frame
// sequencer and free-running sample-clock generator. Assumes the bus
// decoder presents one-cycle control writes on ctl_wr/ctl_wdata.
module sadc_frame_ctrl
    import sadc_pkg::*;
#(
    parameter int QTR_DIV   = 2,
    parameter int RES_W     = 16,
    parameter int LEG_NULLS = 1,
    parameter int EXT_NULLS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTRL_W-1:0] ctl_wdata,
    input  logic              ext_mode,
    input  logic              adc_din,
    output logic              adc_sclk,
    output logic              adc_dout,
    output logic              smp_clk,
    output logic              busy,
    output logic [RES_W-1:0]  result
);

    logic       smp_en;
    logic       launch;
    frame_cfg_t launch_cfg;

    sadc_ctrl_reg #(
        .LEG_NULLS(LEG_NULLS),
        .EXT_NULLS(EXT_NULLS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ext_mode  (ext_mode),
        .busy      (busy),
        .smp_en    (smp_en),
        .launch    (launch),
        .launch_cfg(launch_cfg)
    );

    sadc_frame_seq #(
        .QTR_DIV(QTR_DIV),
        .RES_W  (RES_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .launch_cfg(launch_cfg),
        .adc_din   (adc_din),
        .adc_sclk  (adc_sclk),
        .adc_dout  (adc_dout),
        .busy      (busy),
        .result    (result)
    );

    sadc_smpclk_gen #(
        .QTR_DIV(QTR_DIV)
    ) u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (smp_en),
        .smp_clk(smp_clk)
    );

endmodule

// File: rtl/sadc_frame_ctrl_chk.sv
`timescale 1ns/1ps
// Checker for the serial ADC frame controller, attached by bind. Assumes
// the control word layout from sadc_pkg.
module sadc_frame_ctrl_chk
    import sadc_pkg::*;
#(
    parameter int RES_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [CTRL_W-1:0] ctl_wdata,
    input logic              ext_mode,
    input logic              adc_sclk,
    input logic              adc_dout,
    input logic              smp_clk,
    input logic              smp_en,
    input logic              busy,
    input logic [RES_W-1:0]  result
);

    logic [FLEN_W-1:0] wr_len;
    assign wr_len = ext_mode ? ctl_wdata[12:7] : {1'b0, ctl_wdata[12:8]};

    // R7: the shift clock idles high outside frames.
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> adc_sclk);

    // R7: busy only rises after a start write.
    p_busy_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ctl_wr && ctl_wdata[START_BIT]));

    // R3: data out is stable across the high half of the shift clock.
    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk && $past(adc_sclk)) |-> $stable(adc_dout));

    // R6: a new frame begins with an empty result.
    p_res_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (result == '0));

    // R10: a zero-length start leaves the block idle.
    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[START_BIT] && !busy && wr_len == '0) |=> !busy);

    // R11: the sample clock stays low once disabled.
    p_smp_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_en) |-> !smp_clk);

endmodule

bind sadc_frame_ctrl sadc_frame_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .ext_mode (ext_mode),
    .adc_sclk (adc_sclk),
    .adc_dout (adc_dout),
    .smp_clk  (smp_clk),
    .smp_en   (smp_en),
    .busy     (busy),
    .result   (result)
);

// File: tb/sadc_frame_ctrl_test.sv
`timescale 1ns/1ps
module sadc_frame_ctrl_test;

    localparam int QTR   = 2;
    localparam int RES_W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        ext_mode = 1'b0;
    logic        adc_din = 1'b0;
    logic        adc_sclk, adc_dout, smp_clk, busy;
    logic [RES_W-1:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    bit din_bits [64];
    bit tx_bits  [64];
    int rise_cnt = 0;
    int last_rise = 0;
    int period_bad = 0;
    bit sclk_prev = 1'b1;
    int smp_changes = 0;
    int smp_bad = 0;
    int last_smp = 0;
    bit smp_prev = 1'b0;

    always #2.5 clk = ~clk;

    sadc_frame_ctrl #(.QTR_DIV(QTR), .RES_W(RES_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ext_mode(ext_mode), .adc_din(adc_din), .adc_sclk(adc_sclk),
        .adc_dout(adc_dout), .smp_clk(smp_clk), .busy(busy), .result(result)
    );

    // Converter model and edge monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (adc_sclk && !sclk_prev) begin
                if (rise_cnt < 64) tx_bits[rise_cnt] = adc_dout;
                if (rise_cnt > 0 && (cyc - last_rise) != 4*QTR) period_bad++;
                last_rise = cyc;
                rise_cnt++;
            end
            if (!adc_sclk && sclk_prev) begin
                adc_din <= (rise_cnt < 64) ? din_bits[rise_cnt] : 1'b0;
            end
            if (smp_clk != smp_prev) begin
                if (smp_changes > 0 && (cyc - last_smp) != QTR) smp_bad++;
                last_smp = cyc;
                smp_changes++;
            end
        end
        sclk_prev = adc_sclk;
        smp_prev  = smp_clk;
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input bit ext, input logic [31:0] w);
        return ext ? int'(w[12:7]) : int'(w[12:8]);
    endfunction

    function automatic int exp_cfgn(input bit ext, input logic [31:0] w);
        if (!ext) return 8;
        return (int'(w[6:0]) > 16) ? 16 : int'(w[6:0]);
    endfunction

    function automatic bit exp_cfgbit(input bit ext, input logic [31:0] w, input int k);
        int n = exp_cfgn(ext, w);
        return ext ? w[16 + n - 1 - k] : w[7 - k];
    endfunction

    function automatic int exp_result(input bit ext, input logic [31:0] w);
        int n = exp_len(ext, w);
        int cs = exp_cfgn(ext, w) + (ext ? 3 : 1);
        logic [RES_W-1:0] r = '0;
        for (int k = cs; k < n; k++) r = {r[RES_W-2:0], din_bits[k]};
        return int'(r);
    endfunction

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        ctl_wr = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic start_frame(input bit ext, input logic [31:0] w);
        ext_mode = ext;
        for (int k = 0; k < 64; k++) din_bits[k] = 1'($urandom);
        rise_cnt = 0;
        period_bad = 0;
        do_write(w | 32'h4000);
        chk("R7", int'(busy), (exp_len(ext, w) != 0) ? 1 : 0, "busy after start");
    endtask

    task automatic finish_frame(input bit ext, input logic [31:0] w);
        int n = exp_len(ext, w);
        int cn = exp_cfgn(ext, w);
        int bad_cfg = 0;
        int bad_tail = 0;
        int t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
        chk("R2", rise_cnt, n, "shift clock count");
        chk("R12", period_bad, 0, "shift period errors");
        chk("R7", int'(adc_sclk), 1, "sclk idle after frame");
        for (int k = 0; k < n; k++) begin
            if (k < cn) begin
                if (tx_bits[k] != exp_cfgbit(ext, w, k)) bad_cfg++;
            end else if (tx_bits[k] != 1'b0) begin
                bad_tail++;
            end
        end
        chk(ext ? "R4" : "R3", bad_cfg, 0, "config bit errors");
        chk("R5", bad_tail, 0, "nonzero dout after config");
        chk("R6", int'(result), exp_result(ext, w), "captured result");
    endtask

    task automatic run_frame(input bit ext, input logic [31:0] w);
        start_frame(ext, w);
        finish_frame(ext, w);
    endtask

    // Watchdog: a hung run is reported as a failure.
    initial begin
        #(5.0 * 190000);
        fails++;
        checks++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [31:0] w2;
        bit ext;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", int'(busy), 0, "busy");
        chk("R1", int'(adc_sclk), 1, "sclk");
        chk("R1", int'(adc_dout), 0, "dout");
        chk("R1", int'(result), 0, "result");
        chk("R1", int'(smp_clk), 0, "smp_clk");

        // R3: byte mode, 25 clocks, config 0xA5
        run_frame(1'b0, (32'd25 << 8) | 32'h00A5);
        // R4: extended, 23 clocks, 10 config bits
        run_frame(1'b1, (32'h0000_02D3 << 16) | (32'd23 << 7) | 32'd10);
        // R4: length above the clamp, long result keeps last 16 bits
        run_frame(1'b1, (32'h9C3B << 16) | (32'd40 << 7) | 32'd20);
        // R4: frame shorter than the configuration
        run_frame(1'b1, (32'hF0F0 << 16) | (32'd5 << 7) | 32'd16);
        // R4: zero configuration bits, capture after nulls only
        run_frame(1'b1, (32'hFFFF << 16) | (32'd12 << 7) | 32'd0);

        // R10: zero frame length start
        rise_cnt = 0;
        ext_mode = 1'b0;
        do_write(32'h0000_40FF);
        chk("R10", int'(busy), 0, "busy after zero-length start");
        repeat (30) @(negedge clk);
        chk("R10", rise_cnt, 0, "edges after zero-length start");

        // R8: start while busy is ignored
        w  = (32'd31 << 8) | 32'h0037;
        w2 = (32'd3 << 8) | 32'h00C8;
        start_frame(1'b0, w);
        repeat (20) @(negedge clk);
        do_write(w2 | 32'h4000);
        finish_frame(1'b0, w);
        repeat (40) @(negedge clk);
        chk("R8", rise_cnt, 31, "no second frame after ignored start");
        chk("R8", int'(busy), 0, "still idle after ignored start");

        // R9 and R11: write without start enables the sample clock only
        rise_cnt = 0;
        do_write(32'h2000 | (32'd10 << 8));
        repeat (3) @(negedge clk);
        smp_changes = 0;
        smp_bad = 0;
        repeat (40) @(negedge clk);
        chk("R9", int'(busy), 0, "no frame from write without start");
        chk("R9", rise_cnt, 0, "no shift edges from write without start");
        chk("R11", int'(smp_changes > 10), 1, "sample clock running");
        chk("R11", smp_bad, 0, "sample clock spacing errors");
        // R11: disable and check it stays low
        do_write(32'h0000_0000);
        repeat (2) @(negedge clk);
        smp_changes = 0;
        repeat (40) @(negedge clk);
        chk("R11", smp_changes, 0, "sample clock changes while disabled");
        chk("R11", int'(smp_clk), 0, "sample clock level while disabled");

        // Random frames in both modes
        for (int i = 0; i < 24; i++) begin
            ext = 1'($urandom);
            w = $urandom;
            w[14] = 1'b0;
            w[6:0] = 7'($urandom % 20);
            if (ext && w[12:7] == 6'd0) w[7] = 1'b1;
            if (!ext && w[12:8] == 5'd0) w[8] = 1'b1;
            run_frame(ext, w);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule